// File: doc/BRIEF.md
# Dual-Channel Sequenced Reset Generator

This block turns two supply-good flags and an active-low manual reset button into two active-low reset outputs whose release is ordered. The first output, `rst1_no`, tracks the primary supply flag alone. The second output, `rst2_no`, is held while either supply flag is bad. It is also held while the first output is still asserted. Each output leaves reset only after its own timeout, counted in clock cycles, has run out with no further cause for reset.

All three asynchronous inputs pass through a two-flop synchronizer. The manual reset is then debounced, so it must hold a new level for `DEBOUNCE_CYCLES` synchronized samples before the block acts on it. The primary flag reaches the first channel one register later than it reaches the second channel. As a result, a primary failure always pulls the second output low one cycle before the first.

The second timeout is either the fixed `TIMEOUT_CYCLES` or a programmable count. A select input chooses between them.

Top module: `seq_rst_gen`

## Requirements
- R1: While `rst_ni` is low, and on the first cycles after it rises, both `rst1_no` and `rst2_no` are 0 and both channel counters are cleared.
- R2: If `pri_good_i` is sampled low at clock edge k, `rst1_no` is 0 after edge k+3, whatever `sec_good_i` does.
- R3: If `pri_good_i` is high from edge k onward and the debounced manual reset is released, `rst1_no` rises after edge k+2+`TIMEOUT_CYCLES`.
- R4: If `sec_good_i` or `pri_good_i` is sampled low at edge k, `rst2_no` is 0 after edge k+2.
- R5: On a primary failure, `rst2_no` falls exactly one clock cycle before `rst1_no` falls.
- R6: The second timeout counts only while the synchronized secondary flag is high and `rst1_no` is 1. With the secondary flag already good, `rst2_no` rises exactly T2 edges after `rst1_no` rises.
- R7: T2 = `TIMEOUT_CYCLES` when `sec_prog_sel_i` is 0. When it is 1, T2 = `sec_prog_cnt_i`, and a value of 0 acts as 1. The count is captured on every cycle the second channel is held and stays frozen while that channel counts.
- R8: A secondary-only failure leaves `rst1_no` unchanged. `rst1_no` falls only because of the primary flag or the manual reset.
- R9: Once the debounced manual reset is active, both outputs are 0 on the next cycle. A low level sampled from edge k reaches that state after edge k+2+`DEBOUNCE_CYCLES`. After release, `rst1_no` times out first and `rst2_no` follows.
- R10: A manual-reset low pulse shorter than `DEBOUNCE_CYCLES` samples has no effect on either output.
- R11: Any new cause for reset during a timeout returns that channel's counter to zero, and the full timeout runs again afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low power-on reset, asynchronous assert |
| pri_good_i | input | 1 | Primary supply good flag, asynchronous |
| sec_good_i | input | 1 | Secondary supply good flag, asynchronous |
| man_rst_ni | input | 1 | Manual reset button, active low, asynchronous |
| sec_prog_sel_i | input | 1 | 1 selects the programmable second timeout |
| sec_prog_cnt_i | input | CNT_W | Programmable second timeout in cycles |
| rst1_no | output | 1 | Primary reset output, active low |
| rst2_no | output | 1 | Secondary reset output, active low |

## Verification
The counter-bound and release checks assume two things:
- `sec_prog_cnt_i` fits in `CNT_W` bits.
- `TIMEOUT_CYCLES` fits in `CNT_W` bits.

The checks need no assumption about how stable the programmable count is, because the count is frozen in the channel once counting starts. The random stimulus draws programmable counts only in the range 0 to 30. It changes the select and count inputs freely, including while counting is in progress, to show that the frozen value is the one used. Input segments last from one to fifty cycles. This covers bounces shorter than the debounce window, single-cycle supply glitches in the middle of a timeout, and long stable stretches in which both outputs release.

// File: rtl/seq_rst_pkg.sv
package seq_rst_pkg;

    typedef enum logic [1:0] {
        PH_HELD     = 2'd0,
        PH_COUNT    = 2'd1,
        PH_RELEASED = 2'd2
    } chan_phase_e;

    localparam int unsigned SYNC_DEPTH = 2;

endpackage

// File: rtl/seq_rst_sync.sv
module seq_rst_sync #(
    parameter int unsigned W      = 3,
    parameter int unsigned STAGES = 2,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk_i,
    input  logic         rst_ni,
    input  logic [W-1:0] async_i,
    output logic [W-1:0] sync_o
);

    logic [STAGES-1:0][W-1:0] stage_d, stage_q;

    assign stage_d[0] = async_i;

    for (genvar gi = 1; gi < STAGES; gi++) begin : g_chain
        assign stage_d[gi] = stage_q[gi-1];
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            stage_q <= {STAGES{RST_VAL}};
        end else begin
            stage_q <= stage_d;
        end
    end

    assign sync_o = stage_q[STAGES-1];

endmodule

// File: rtl/seq_rst_debounce.sv
module seq_rst_debounce #(
    parameter int unsigned CYCLES = 4
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic din_i,
    output logic dout_o
);

    localparam int unsigned DW = (CYCLES < 2) ? 1 : $clog2(CYCLES + 1);

    typedef struct packed {
        logic [DW-1:0] cnt;
        logic          val;
    } db_state_t;

    db_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (din_i == st_q.val) begin
            st_d.cnt = '0;
        end else if (st_q.cnt == DW'(CYCLES - 1)) begin
            st_d.val = din_i;
            st_d.cnt = '0;
        end else begin
            st_d.cnt = st_q.cnt + DW'(1);
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '{cnt: '0, val: 1'b1};
        end else begin
            st_q <= st_d;
        end
    end

    assign dout_o = st_q.val;

    // R10: the output only ever moves toward the level just sampled
    a_r10_follow_input: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (st_q.val != $past(st_q.val)) |-> (st_q.val == $past(din_i)));

    // R10: the run counter never reaches the window length
    a_r10_cnt_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
        st_q.cnt < DW'(CYCLES));

endmodule

// File: rtl/seq_rst_channel.sv
module seq_rst_channel
    import seq_rst_pkg::*;
#(
    parameter int unsigned CNT_W = 8
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             hold_i,
    input  logic [CNT_W-1:0] lim_i,
    output logic             rel_o
);

    typedef struct packed {
        chan_phase_e      phase;
        logic [CNT_W-1:0] cnt;
        logic [CNT_W-1:0] lim;
    } ch_state_t;

    ch_state_t        st_d, st_q;
    logic [CNT_W-1:0] lim_eff;

    assign lim_eff = (lim_i == '0) ? CNT_W'(1) : lim_i;

    always_comb begin
        st_d = st_q;
        if (hold_i) begin
            st_d.phase = PH_HELD;
            st_d.cnt   = '0;
            st_d.lim   = lim_eff;
        end else begin
            unique case (st_q.phase)
                PH_HELD, PH_COUNT: begin
                    if (st_q.cnt == st_q.lim - CNT_W'(1)) begin
                        st_d.phase = PH_RELEASED;
                    end else begin
                        st_d.phase = PH_COUNT;
                        st_d.cnt   = st_q.cnt + CNT_W'(1);
                    end
                end
                PH_RELEASED: st_d.phase = PH_RELEASED;
                default:     st_d.phase = PH_HELD;
            endcase
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '{phase: PH_HELD, cnt: '0, lim: CNT_W'(1)};
        end else begin
            st_q <= st_d;
        end
    end

    assign rel_o = (st_q.phase == PH_RELEASED);

    // R11: a cause for reset clears the counter on the following cycle
    a_r11_restart: assert property (@(posedge clk_i) disable iff (!rst_ni)
        hold_i |=> (st_q.phase == PH_HELD && st_q.cnt == '0));

    // R7: the counter never passes the captured limit
    a_r7_cnt_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (st_q.phase != PH_RELEASED) |-> (st_q.cnt < st_q.lim));

    // R3: release happens only at the end of a full count
    a_r3_full_count: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(rel_o) |-> ($past(st_q.cnt) == st_q.lim - CNT_W'(1)));

    // R7: the captured limit is frozen while counting
    a_r7_lim_frozen: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!hold_i && st_q.phase == PH_COUNT) |=> $stable(st_q.lim));

endmodule

// File: rtl/seq_rst_gen.sv
module seq_rst_gen
    import seq_rst_pkg::*;
#(
    parameter int unsigned TIMEOUT_CYCLES  = 20,
    parameter int unsigned DEBOUNCE_CYCLES = 4,
    parameter int unsigned CNT_W           = 8
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             pri_good_i,
    input  logic             sec_good_i,
    input  logic             man_rst_ni,
    input  logic             sec_prog_sel_i,
    input  logic [CNT_W-1:0] sec_prog_cnt_i,
    output logic             rst1_no,
    output logic             rst2_no
);

    localparam int unsigned      NSYNC   = 3;
    localparam logic [CNT_W-1:0] FIX_LIM = CNT_W'(TIMEOUT_CYCLES);

    typedef struct packed {
        logic pri_dly;
    } top_state_t;

    top_state_t       st_d, st_q;
    logic [NSYNC-1:0] sync_vec;
    logic             pri_s, sec_s, mr_s, mr_deb;
    logic             hold1, hold2;
    logic [CNT_W-1:0] lim2;
    logic             rel1, rel2;

    seq_rst_sync #(
        .W      (NSYNC),
        .STAGES (SYNC_DEPTH),
        .RST_VAL(3'b100)
    ) i_sync (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .async_i({man_rst_ni, sec_good_i, pri_good_i}),
        .sync_o (sync_vec)
    );

    assign pri_s = sync_vec[0];
    assign sec_s = sync_vec[1];
    assign mr_s  = sync_vec[2];

    seq_rst_debounce #(
        .CYCLES(DEBOUNCE_CYCLES)
    ) i_mr_db (
        .clk_i (clk_i),
        .rst_ni(rst_ni),
        .din_i (mr_s),
        .dout_o(mr_deb)
    );

    always_comb begin
        st_d         = st_q;
        st_d.pri_dly = pri_s;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '{pri_dly: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    assign hold1 = !st_q.pri_dly || !mr_deb;
    assign hold2 = !pri_s || !sec_s || !mr_deb || !rel1;
    assign lim2  = sec_prog_sel_i ? sec_prog_cnt_i : FIX_LIM;

    seq_rst_channel #(
        .CNT_W(CNT_W)
    ) i_ch1 (
        .clk_i (clk_i),
        .rst_ni(rst_ni),
        .hold_i(hold1),
        .lim_i (FIX_LIM),
        .rel_o (rel1)
    );

    seq_rst_channel #(
        .CNT_W(CNT_W)
    ) i_ch2 (
        .clk_i (clk_i),
        .rst_ni(rst_ni),
        .hold_i(hold2),
        .lim_i (lim2),
        .rel_o (rel2)
    );

    assign rst1_no = rel1;
    assign rst2_no = rel2;

    // R2: delayed primary flag low forces the first output low
    a_r2_pri_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !st_q.pri_dly |=> !rst1_no);

    // R4: either synchronized supply flag low forces the second output low
    a_r4_sec_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!sec_s || !pri_s) |=> !rst2_no);

    // R5: the first output never falls while the second is still high
    a_r5_assert_order: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $fell(rst1_no) |-> !rst2_no);

    // R6: the second output rises only after the first has been high a cycle
    a_r6_release_order: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(rst2_no) |-> (rst1_no && $past(rst1_no)));

    // R8: only the primary flag or the manual reset can drop the first output
    a_r8_pri_only: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $fell(rst1_no) |-> ($past(!st_q.pri_dly) || $past(!mr_deb)));

    // R9: debounced manual reset holds both outputs
    a_r9_manual_both: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !mr_deb |=> (!rst1_no && !rst2_no));

endmodule

// File: tb/test_seq_rst_gen.sv
module test_seq_rst_gen;

    localparam int T  = 20;
    localparam int D  = 4;
    localparam int CW = 8;

    logic          clk = 1'b0;
    logic          rst_ni;
    logic          pri, sec, mr, sel;
    logic [CW-1:0] prog;
    logic          r1, r2;

    int checks   = 0;
    int failures = 0;

    always #5 clk = ~clk;

    seq_rst_gen #(
        .TIMEOUT_CYCLES (T),
        .DEBOUNCE_CYCLES(D),
        .CNT_W          (CW)
    ) i_seq_rst_gen (
        .clk_i         (clk),
        .rst_ni        (rst_ni),
        .pri_good_i    (pri),
        .sec_good_i    (sec),
        .man_rst_ni    (mr),
        .sec_prog_sel_i(sel),
        .sec_prog_cnt_i(prog),
        .rst1_no       (r1),
        .rst2_no       (r2)
    );

    // Reference model built from the requirement latencies
    typedef struct {
        int cnt;
        int lim;
        bit rel;
    } mch_t;

    bit   m_p1, m_p2, m_s1, m_s2, m_m1, m_m2, m_pd, m_deb;
    int   m_dcnt;
    mch_t m_c1, m_c2;

    function automatic mch_t ch_step(mch_t s, bit hold, int lim_in);
        mch_t n = s;
        if (hold) begin
            n.cnt = 0;
            n.rel = 0;
            n.lim = (lim_in == 0) ? 1 : lim_in;
        end else if (!s.rel) begin
            if (s.cnt == s.lim - 1) n.rel = 1;
            else                    n.cnt = s.cnt + 1;
        end
        return n;
    endfunction

    function automatic int exp_sec_lim(bit s, int p);
        return s ? p : T;
    endfunction

    always @(posedge clk or negedge rst_ni) begin
        if (!rst_ni) begin
            m_p1 = 0; m_p2 = 0; m_s1 = 0; m_s2 = 0; m_pd = 0;
            m_m1 = 1; m_m2 = 1; m_deb = 1; m_dcnt = 0;
            m_c1 = '{cnt: 0, lim: 1, rel: 0};
            m_c2 = '{cnt: 0, lim: 1, rel: 0};
        end else begin
            bit   h1, h2, ndeb;
            int   ndcnt;
            mch_t n1, n2;
            h1 = !m_pd || !m_deb;
            h2 = !m_p2 || !m_s2 || !m_deb || !m_c1.rel;
            n1 = ch_step(m_c1, h1, T);
            n2 = ch_step(m_c2, h2, exp_sec_lim(sel, int'(prog)));
            ndeb = m_deb; ndcnt = m_dcnt;
            if (m_m2 == m_deb)      ndcnt = 0;
            else if (m_dcnt == D-1) begin ndeb = m_m2; ndcnt = 0; end
            else                    ndcnt = m_dcnt + 1;
            m_pd = m_p2; m_p2 = m_p1; m_p1 = pri;
            m_s2 = m_s1; m_s1 = sec;
            m_m2 = m_m1; m_m1 = mr;
            m_deb = ndeb; m_dcnt = ndcnt;
            m_c1 = n1; m_c2 = n2;
        end
    end

    task automatic chk(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    bit model_on = 0;
    always @(negedge clk) begin
        if (model_on && rst_ni) begin
            chk("R3 model rst1", int'(r1), int'(m_c1.rel));
            chk("R6 model rst2", int'(r2), int'(m_c2.rel));
        end
    end

    task automatic wait_for(int which, logic val, output int n);
        n = 0;
        do begin
            @(negedge clk);
            n++;
        end while (((which == 1) ? r1 : r2) !== val && n < 1000);
    endtask

    task automatic report();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        failures++;
        $display("FAIL R1 watchdog actual=hung expected=done");
        report();
    end

    initial begin
        int n, lows;
        void'($urandom(32'd2024));
        rst_ni = 0; pri = 0; sec = 0; mr = 1; sel = 0; prog = '0;
        repeat (4) @(negedge clk);
        chk("R1 rst1 in reset", int'(r1), 0);
        chk("R1 rst2 in reset", int'(r2), 0);
        rst_ni = 1;
        model_on = 1;
        repeat (3) @(negedge clk);
        chk("R1 rst1 after reset", int'(r1), 0);
        chk("R1 rst2 after reset", int'(r2), 0);

        // R3 and R6: fixed timeouts
        pri = 1; sec = 1;
        wait_for(1, 1'b1, n); chk("R3 rst1 release", n, T + 3);
        wait_for(2, 1'b1, n); chk("R6 rst2 after rst1", n, T);

        // R4 and R8: secondary-only failure
        sec = 0;
        wait_for(2, 1'b0, n); chk("R4 rst2 falls", n, 3);
        repeat (10) @(negedge clk);
        chk("R8 rst1 untouched", int'(r1), 1);
        sel = 1; prog = CW'(5); sec = 1;
        wait_for(2, 1'b1, n); chk("R7 programmed five", n, 2 + 5);

        // R2 and R5: primary failure order
        pri = 0;
        wait_for(2, 1'b0, n); chk("R4 rst2 on primary drop", n, 3);
        chk("R5 rst1 still high", int'(r1), 1);
        wait_for(1, 1'b0, n); chk("R5 rst1 one cycle later", n, 1);

        // R7: programmed zero acts as one
        prog = '0; pri = 1;
        wait_for(1, 1'b1, n); chk("R3 rst1 release again", n, T + 3);
        wait_for(2, 1'b1, n); chk("R7 zero acts as one", n, 1);

        // R11: glitch during timeout restarts
        sel = 0; pri = 0;
        wait_for(1, 1'b0, n); chk("R2 rst1 falls", n, 4);
        pri = 1;
        repeat (10) @(negedge clk);
        pri = 0;
        @(negedge clk);
        pri = 1;
        wait_for(1, 1'b1, n); chk("R11 full restart", n, T + 3);
        wait_for(2, 1'b1, n); chk("R11 rst2 after restart", n, T);

        // R10: short manual pulse ignored
        mr = 0;
        repeat (D - 1) @(negedge clk);
        mr = 1;
        lows = 0;
        for (int i = 0; i < 12; i++) begin
            @(negedge clk);
            if (!r1 || !r2) lows++;
        end
        chk("R10 short pulse ignored", lows, 0);

        // R9: manual reset
        mr = 0;
        wait_for(2, 1'b0, n); chk("R9 rst2 manual", n, 3 + D);
        chk("R9 rst1 manual", int'(r1), 0);
        repeat (5) @(negedge clk);
        mr = 1;
        wait_for(1, 1'b1, n); chk("R9 rst1 after manual", n, 6 + T);
        wait_for(2, 1'b1, n); chk("R9 rst2 after manual", n, T);

        // Random phase, checked by the model each cycle
        for (int seg = 0; seg < 200; seg++) begin
            int len;
            len  = $urandom_range(1, 50);
            pri  = ($urandom_range(0, 9) != 0);
            sec  = ($urandom_range(0, 7) != 0);
            mr   = ($urandom_range(0, 9) != 0);
            sel  = $urandom_range(0, 1);
            prog = CW'($urandom_range(0, 30));
            repeat (len) @(negedge clk);
        end
        model_on = 0;
        report();
    end

endmodule